// File: doc/BRIEF.md
# Page Write Staging and Commit Unit

This block sits behind a serial memory front end that has already decoded the bus traffic into byte-level events. A write transaction opens with a start event that carries the full byte address. Each data byte that follows is held in a staging buffer of one page. A flag for each byte in that buffer records whether it was written. Nothing reaches the storage array while the transaction is open.

When the closing stop event arrives, all staged bytes go into the addressed page on one clock edge. Bytes of the page that were not written keep their old contents. The block then raises a busy indication for a fixed, parameterised number of cycles. This stands in for the programming time of a nonvolatile array. While busy, the block ignores every incoming event.

Within a transaction, the byte position advances only in the low address bits. Long bursts therefore wrap around inside the page, and later bytes overwrite earlier ones. A current-address pointer is published for the read side to use. A transaction that carries no data bytes, such as the address phase of a random read, moves only that pointer. A write that protection logic rejects leaves both the array and the pointer untouched. The storage array is a resettable register array whose erased value is all ones.

Top module: `page_write_commit`

## Requirements
- R1: After reset every array byte reads 8'hFF, `busy_o` is 0 and `cur_addr_o` is 0.
- R2: Bytes accepted during an open transaction do not change the array before the stop event.
- R3: On a stop event after one or more bytes, every staged byte is written on the same edge at address {page, position}. Bytes of that page that were not staged keep their previous value.
- R4: The position is the low 4 address bits (16-byte pages) and increments by one, modulo 16, after each byte. The page bits never change within a transaction, so a 17th and later byte overwrites the byte staged earlier at the same position.
- R5: A committing stop raises `busy_o` on the following edge. It stays high for exactly BUSY_CYCLES clock cycles.
- R6: While `busy_o` is high, start, byte, stop and reject events are ignored. They change neither the array, `cur_addr_o`, nor the busy window, and a start given while busy opens no transaction.
- R7: A stop event in a transaction that has no data bytes starts no busy window and writes nothing. It sets `cur_addr_o` to the start address.
- R8: A reject event clears the staged bytes and closes the transaction. Later bytes and the stop commit nothing, raise no busy window and leave `cur_addr_o` unchanged.
- R9: After a commit, `cur_addr_o` holds {page, position after the last staged byte}.
- R10: Byte and stop events that arrive with no transaction open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start_i | input | 1 | Opens a write transaction at `wr_addr_i` |
| wr_addr_i | input | 7 | Full byte address: page in bits 6:4, position in bits 3:0 |
| byte_valid_i | input | 1 | One data byte present on `byte_i` |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Closes the transaction and commits if bytes are staged |
| wp_reject_i | input | 1 | Write rejected by protection; discards the staged bytes |
| rd_addr_i | input | 7 | Array read address |
| rd_data_o | output | 8 | Array content at `rd_addr_i`, combinational |
| busy_o | output | 1 | Programming window in progress |
| cur_addr_o | output | 7 | Current-address pointer |

## Verification
Each event is driven for one cycle from a falling edge. Its effect comes through exactly one register, so the bench reads `busy_o`, `cur_addr_o` and the array at the very next falling edge after the stop or reject. Because `rd_data_o` is combinational from the array, a full-array sweep taken in that half cycle shows the committed page already updated. The busy window is measured by counting falling edges on which `busy_o` is high, starting with the first edge after the stop. That count must equal BUSY_CYCLES, and events injected during the window are included in it.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic {
      SESS_IDLE = 1'b0,
      SESS_OPEN = 1'b1
   } sess_e;
endpackage

// File: rtl/pgwr_stage.sv
module pgwr_stage
   import pgwr_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 16,
   parameter int PAGES      = 8
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    busy_i,
   input  logic                                    start_i,
   input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]     start_addr_i,
   input  logic                                    byte_we_i,
   input  logic [DATA_W-1:0]                       byte_i,
   input  logic                                    stop_i,
   input  logic                                    reject_i,
   output logic                                    commit_o,
   output logic                                    ptr_we_o,
   output logic [$clog2(PAGES)-1:0]                page_o,
   output logic [$clog2(PAGE_BYTES)-1:0]           ofs_o,
   output logic [PAGE_BYTES-1:0][DATA_W-1:0]       data_o,
   output logic [PAGE_BYTES-1:0]                   valid_o
);
   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int ADDR_W = $clog2(PAGES*PAGE_BYTES);

   sess_e                             sess_q;
   logic [ADDR_W-OFS_W-1:0]           page_q;
   logic [OFS_W-1:0]                  ofs_q;
   logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;
   logic [PAGE_BYTES-1:0]             valid_q;
   logic                              close_w;

   // a stop or reject only counts when a transaction is open and idle
   assign close_w  = !busy_i && !start_i && (sess_q == SESS_OPEN) && stop_i && !reject_i;
   assign commit_o = close_w && (|valid_q);
   assign ptr_we_o = close_w;
   assign page_o   = page_q;
   assign ofs_o    = ofs_q;
   assign data_o   = data_q;
   assign valid_o  = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sess_q  <= SESS_IDLE;
         page_q  <= '0;
         ofs_q   <= '0;
         data_q  <= '0;
         valid_q <= '0;
      end else if (!busy_i) begin
         if (start_i) begin
            sess_q  <= SESS_OPEN;
            page_q  <= start_addr_i[ADDR_W-1:OFS_W];
            ofs_q   <= start_addr_i[OFS_W-1:0];
            valid_q <= '0;
         end else if (sess_q == SESS_OPEN) begin
            if (reject_i || stop_i) begin
               sess_q  <= SESS_IDLE;
               valid_q <= '0;
            end else if (byte_we_i) begin
               data_q[ofs_q]  <= byte_i;
               valid_q[ofs_q] <= 1'b1;
               ofs_q          <= ofs_q + 1'b1;   // wraps inside the page
            end
         end
      end
   end
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
   parameter int BUSY_CYCLES = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
   parameter int                DATA_W     = 8,
   parameter int                PAGE_BYTES = 16,
   parameter int                PAGES      = 8,
   parameter logic [DATA_W-1:0] ERASE_VAL  = '1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               commit_i,
   input  logic [$clog2(PAGES)-1:0]           page_i,
   input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  data_i,
   input  logic [PAGE_BYTES-1:0]              valid_i,
   input  logic [$clog2(PAGES*PAGE_BYTES)-1:0] rd_addr_i,
   output logic [DATA_W-1:0]                  rd_data_o
);
   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int DEPTH = PAGES * PAGE_BYTES;

   logic [DATA_W-1:0]     mem_q [DEPTH];
   logic [PAGE_BYTES-1:0] lane_we;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
      assign lane_we[g] = commit_i & valid_i[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASE_VAL;
      end else begin
         for (int b = 0; b < PAGE_BYTES; b++) begin
            if (lane_we[b]) mem_q[{page_i, OFS_W'(b)}] <= data_i[b];
         end
      end
   end

   assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit #(
   parameter int                DATA_W      = 8,
   parameter int                PAGE_BYTES  = 16,
   parameter int                PAGES       = 8,
   parameter int                BUSY_CYCLES = 250,
   parameter logic [DATA_W-1:0] ERASE_VAL   = '1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_start_i,
   input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]  wr_addr_i,
   input  logic                                 byte_valid_i,
   input  logic [DATA_W-1:0]                    byte_i,
   input  logic                                 stop_i,
   input  logic                                 wp_reject_i,
   input  logic [$clog2(PAGES*PAGE_BYTES)-1:0]  rd_addr_i,
   output logic [DATA_W-1:0]                    rd_data_o,
   output logic                                 busy_o,
   output logic [$clog2(PAGES*PAGE_BYTES)-1:0]  cur_addr_o
);
   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = $clog2(PAGES);
   localparam int ADDR_W = PAGE_W + OFS_W;

   if (PAGE_BYTES < 2 || PAGE_BYTES != (1 << OFS_W)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (PAGES < 2 || PAGES != (1 << PAGE_W)) begin : g_bad_pages
      $error("PAGES must be a power of two of at least 2");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   logic                              commit_w;
   logic                              ptr_we_w;
   logic [PAGE_W-1:0]                 page_w;
   logic [OFS_W-1:0]                  ofs_w;
   logic [PAGE_BYTES-1:0][DATA_W-1:0] data_w;
   logic [PAGE_BYTES-1:0]             valid_w;
   logic [ADDR_W-1:0]                 ptr_q;

   pgwr_stage #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES)) u_stage (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_o),
      .start_i(wr_start_i), .start_addr_i(wr_addr_i),
      .byte_we_i(byte_valid_i), .byte_i(byte_i),
      .stop_i(stop_i), .reject_i(wp_reject_i),
      .commit_o(commit_w), .ptr_we_o(ptr_we_w),
      .page_o(page_w), .ofs_o(ofs_w), .data_o(data_w), .valid_o(valid_w)
   );

   pgwr_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(commit_w), .busy_o(busy_o)
   );

   pgwr_array #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES),
                .ERASE_VAL(ERASE_VAL)) u_array (
      .clk(clk), .rst_n(rst_n), .commit_i(commit_w), .page_i(page_w),
      .data_i(data_w), .valid_i(valid_w),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (ptr_we_w) ptr_q <= {page_w, ofs_w};
   end

   assign cur_addr_o = ptr_q;
endmodule

// File: rtl/page_write_commit_chk.sv
module page_write_commit_chk #(
   parameter int BUSY_CYCLES = 250,
   parameter int ADDR_W      = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_i,
   input logic              busy_o,
   input logic [ADDR_W-1:0] cur_addr_o
);
   localparam int CW = $clog2(BUSY_CYCLES + 2);

   logic [CW-1:0] win_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      win_cnt <= '0;
      else if (busy_o) win_cnt <= win_cnt + 1'b1;
      else             win_cnt <= '0;
   end

   // R5
   busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (win_cnt < CW'(BUSY_CYCLES)));

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (win_cnt == CW'(BUSY_CYCLES)));

   // R7
   busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_i));

   // R6
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(cur_addr_o));
endmodule

bind page_write_commit page_write_commit_chk #(
   .BUSY_CYCLES(BUSY_CYCLES), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .busy_o(busy_o), .cur_addr_o(cur_addr_o)
);

// File: tb/page_write_commit_bench.sv
`timescale 1ns/1ps
module page_write_commit_bench;
   localparam int N     = 40;
   localparam int DEPTH = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_start = 1'b0;
   logic [6:0] wr_addr = '0;
   logic       byte_valid = 1'b0;
   logic [7:0] byte_d = '0;
   logic       stop = 1'b0;
   logic       reject = 1'b0;
   logic [6:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       busy;
   logic [6:0] cur_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] ref_mem [DEPTH];

   always #2 clk = ~clk;

   page_write_commit #(.BUSY_CYCLES(N)) u_page_write_commit (
      .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start), .wr_addr_i(wr_addr),
      .byte_valid_i(byte_valid), .byte_i(byte_d), .stop_i(stop),
      .wp_reject_i(reject), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .busy_o(busy), .cur_addr_o(cur_addr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // one-cycle event drivers, entered and left on a falling edge
   task automatic ev_start(input logic [6:0] a);
      wr_start = 1'b1; wr_addr = a; @(negedge clk); wr_start = 1'b0;
   endtask
   task automatic ev_byte(input logic [7:0] d);
      byte_valid = 1'b1; byte_d = d; @(negedge clk); byte_valid = 1'b0;
   endtask
   task automatic ev_stop();
      stop = 1'b1; @(negedge clk); stop = 1'b0;
   endtask
   task automatic ev_reject();
      reject = 1'b1; @(negedge clk); reject = 1'b0;
   endtask

   task automatic check_mem(input string req);
      int bad = 0;
      int first = -1;
      logic [7:0] act = '0;
      for (int i = 0; i < DEPTH; i++) begin
         rd_addr = 7'(i);
         #0.01;
         if (rd_data !== ref_mem[i]) begin
            if (first < 0) begin first = i; act = rd_data; end
            bad++;
         end
      end
      chk(bad == 0, req, $sformatf("array byte 0x%0h", first), int'(act),
          (first < 0) ? 0 : int'(ref_mem[first]));
   endtask

   task automatic finish_busy(input int pre, input string req);
      int cnt = pre;
      while (busy) begin cnt++; @(negedge clk); end
      chk(cnt == N, req, "busy window length", cnt, N);
   endtask

   // complete write of n bytes base, base+1, ... starting at a
   task automatic write_txn(input logic [6:0] a, input int n, input logic [7:0] base,
                            input string req);
      logic [3:0] ofs = a[3:0];
      ev_start(a);
      for (int i = 0; i < n; i++) begin
         ev_byte(base + 8'(i));
      end
      for (int i = 0; i < n; i++) begin
         ref_mem[{a[6:4], ofs}] = base + 8'(i);
         ofs = ofs + 4'd1;
      end
      ev_stop();
      chk(busy == 1'b1, "R5", "busy after commit", int'(busy), 1);
      chk(cur_addr == {a[6:4], ofs}, req, "pointer after commit",
          int'(cur_addr), int'({a[6:4], ofs}));
      check_mem(req);
      finish_busy(0, "R5");
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      chk(cur_addr == 7'h00, "R1", "pointer after reset", int'(cur_addr), 0);
      check_mem("R1");
   endtask

   task automatic t_no_session();
      ev_byte(8'h33);
      ev_stop();
      chk(busy == 1'b0, "R10", "busy after orphan stop", int'(busy), 0);
      chk(cur_addr == 7'h00, "R10", "pointer after orphan stop", int'(cur_addr), 0);
      check_mem("R10");
   endtask

   task automatic t_byte_and_busy_ignore();
      int pre = 0;
      ev_start(7'h23);
      ev_byte(8'h5A);
      rd_addr = 7'h23; #0.01;
      chk(rd_data == 8'hFF, "R2", "array before stop", int'(rd_data), 8'hFF);
      ev_stop();
      ref_mem[7'h23] = 8'h5A;
      chk(busy == 1'b1, "R5", "busy after commit", int'(busy), 1);
      chk(cur_addr == 7'h24, "R9", "pointer after one byte", int'(cur_addr), 7'h24);
      check_mem("R3");
      // events during busy must be ignored
      if (busy) pre++;
      ev_start(7'h40);
      if (busy) pre++;
      ev_byte(8'h11);
      if (busy) pre++;
      ev_stop();
      finish_busy(pre, "R6");
      chk(cur_addr == 7'h24, "R6", "pointer after ignored events", int'(cur_addr), 7'h24);
      check_mem("R6");
      ev_stop();
      chk(busy == 1'b0, "R6", "no transaction opened while busy", int'(busy), 0);
   endtask

   task automatic t_dummy();
      ev_start(7'h55);
      ev_stop();
      chk(busy == 1'b0, "R7", "busy after empty transaction", int'(busy), 0);
      chk(cur_addr == 7'h55, "R7", "pointer after empty transaction", int'(cur_addr), 7'h55);
      check_mem("R7");
   endtask

   task automatic t_reject();
      ev_start(7'h60);
      ev_byte(8'hAA);
      ev_byte(8'hAB);
      ev_reject();
      ev_byte(8'hAC);
      ev_stop();
      chk(busy == 1'b0, "R8", "busy after rejected write", int'(busy), 0);
      chk(cur_addr == 7'h55, "R8", "pointer after rejected write", int'(cur_addr), 7'h55);
      check_mem("R8");
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_session();
      t_byte_and_busy_ignore();
      write_txn(7'h1E, 18, 8'h80, "R4");   // wraps inside page 1
      write_txn(7'h22, 2, 8'hC0, "R3");    // partial page, neighbours kept
      t_dummy();
      t_reject();
      write_txn(7'h7F, 2, 8'h10, "R4");    // last page wraps to its start
      write_txn(7'h05, 16, 8'h40, "R9");   // full page lands back on start
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule